// File: doc/BRIEF.md
# Buffered Serial Transmitter with Selectable Framing

This block serializes characters onto one asynchronous output line. Software-style writes place characters into a small first-in first-out holding store. Whenever the shifter is free and transmission is armed, the oldest character moves into the shifter. The shifter then sends a start bit, the data bits, an optional parity bit and one or two stop bits. Each bit takes one period of an internal baud divider.

The character width and parity come from a 2-bit format select, and a separate bit chooses the number of stop bits. A module enable governs the whole block. Dropping it abandons any frame in progress, empties the store and clears the divider. A transmit enable arms the shifter. The divider counts from zero when transmission is armed, so a character that was queued beforehand leaves at once. Three outputs report status: a buffer-full flag, a shifter-empty flag and a single-cycle interrupt pulse. The interrupt pulse fires either on every hand-over from store to shifter, or only once everything has drained.

Top module: `sertx_top`

## Requirements
- R1: After reset `tx_line` is 1, `shift_empty` is 1, `buf_full` is 0 and `tx_irq` is 0. `tx_line` is 1 whenever `shift_empty` is 1.
- R2: A frame has the following parts: a 0 start bit, data bits least significant first, the parity bit if one is selected, and 1-valued stop bits. Every bit lasts exactly `divisor`+1 clock cycles.
- R3: `fmt_sel` encodings: 00 selects 8 data bits with no parity, 01 selects 8 bits with even parity, 10 selects 8 bits with odd parity, and 11 selects 9 bits with no parity. The 8-bit formats send `wr_data[7:0]` and the 9-bit format sends `wr_data[8:0]`. Higher write bits have no effect on the line.
- R4: `two_stop` = 0 sends one stop bit and `two_stop` = 1 sends two. `shift_empty` returns to 1 exactly at the end of the last stop bit.
- R5: The holding store keeps 4 characters. `buf_full` is 1 while 4 are held. A write while full is discarded, and the held characters still leave in their original order.
- R6: While a frame is being shifted, 4 further writes are accepted, so 5 characters are pending in total, and a sixth write is discarded.
- R7: A character is queued while disarmed. If `tx_en` is then sampled high at edge E, `tx_line` falls to the start bit at edge E+1.
- R8: Once armed at edge E, baud ticks recur every `divisor`+1 cycles from E. A character written while the shifter is idle leaves the store one edge after its write edge, which clears `shift_empty`. Its start bit then begins at the first edge E+k·(`divisor`+1)+1 that follows that hand-over.
- R9: Arming needs a 0-to-1 change of `tx_en` while `mod_en` is 1. A `tx_en` level held high across a module disable does not re-arm. Clearing `tx_en` lets the current frame finish and keeps later characters queued.
- R10: Sampling `mod_en` = 0 forces `tx_line` to 1 and `shift_empty` to 1 on the next edge, and clears `buf_full`. It also discards all queued characters. Writes while disabled are ignored.
- R11: With `irq_mode` = 0, `tx_irq` pulses for exactly one cycle in the first cycle a character has moved from the store into the shifter.
- R12: With `irq_mode` = 1, `tx_irq` pulses once, in the cycle `shift_empty` returns to 1 with the store empty, and not on hand-overs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Module enable; low aborts and flushes |
| tx_en | input | 1 | Transmit enable; a rising change arms the shifter |
| fmt_sel | input | 2 | Data width and parity select |
| two_stop | input | 1 | 1 selects two stop bits |
| divisor | input | 16 | Bit period minus one, in clocks |
| irq_mode | input | 1 | 0: pulse per hand-over; 1: pulse when fully drained |
| wr_valid | input | 1 | Write strobe for `wr_data` |
| wr_data | input | 16 | Character to queue in the low bits |
| tx_line | output | 1 | Serial output, idles high |
| buf_full | output | 1 | All holding entries occupied |
| shift_empty | output | 1 | Shifter holds no character |
| tx_irq | output | 1 | Single-cycle interrupt pulse |

## Verification
The bench decodes every combination of format and stop count. If parity had the wrong sense or the 9th bit were dropped, the decoded data or parity would differ. If the stop count were wrong, `shift_empty` would rise a bit period early or late. It also checks exact start-bit edges in both arming orders. A divider that was not cleared on arming would delay the first character, and one that ignored the free-running phase would start a character written later too soon. It overfills the store while it waits and again while a frame is in flight. An overwrite would corrupt the order or send a sixth character. It also drops enables mid-frame. A level-sensitive arm would restart after a module disable, and an incomplete flush would send stale characters.

// File: rtl/sertx_pkg.sv
// Shared types for the serial transmitter.
// Assumes: the format code values are fixed by the requirements (R3).
package sertx_pkg;

    typedef enum logic [1:0] {
        FMT_8N = 2'b00,
        FMT_8E = 2'b01,
        FMT_8O = 2'b10,
        FMT_9N = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_WAIT = 2'b01,
        ST_SEND = 2'b10
    } tx_st_e;

endpackage

// File: rtl/sertx_fifo.sv
// Holding store for queued characters, first in first out.
// Assumes: the caller may assert wr_en while full; such writes are dropped.
// flush empties the store in one cycle without touching the contents.
module sertx_fifo #(
    parameter int WIDTH = 9,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             empty,
    output logic             full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic [CNT_W-1:0] cnt;
    logic             do_wr, do_rd;

    assign do_wr   = wr_en && (cnt != FULL_CNT);
    assign do_rd   = rd_en && (cnt != '0);
    assign rd_data = mem[rp];
    assign empty   = (cnt == '0);
    assign full    = (cnt == FULL_CNT);

    // Store an accepted character at the write pointer.
    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wp] <= wr_data;
        end
    end

    // Advance pointers and occupancy; flush or reset empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_wr) begin
                wp <= (wp == LAST_PTR) ? '0 : wp + PTR_W'(1);
            end
            if (do_rd) begin
                rp <= (rp == LAST_PTR) ? '0 : rp + PTR_W'(1);
            end
            case ({do_wr, do_rd})
                2'b10:   cnt <= cnt + CNT_W'(1);
                2'b01:   cnt <= cnt - CNT_W'(1);
                default: cnt <= cnt;
            endcase
        end
    end

endmodule

// File: rtl/sertx_baud.sv
// Bit-period divider: emits a tick in the first cycle of every period of divisor+1 clocks.
// Assumes: the counter restarts from zero whenever run is low, so the first
// cycle with run high always carries a tick.
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt == '0);

    // Count through one bit period and wrap; hold cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt >= divisor) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

endmodule

// File: rtl/sertx_shifter.sv
// Frame builder and shift register. It takes one character from the store,
// waits for a baud tick, then emits start, data, parity and stop bits,
// one per tick. Back-to-back characters follow without an idle bit.
// Assumes: abort is synchronous and has priority over everything else.
module sertx_shifter
    import sertx_pkg::*;
#(
    parameter int CHAR_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort,
    input  logic              arm,
    input  logic              tick,
    input  fmt_e              fmt,
    input  logic              two_stop,
    input  logic              fifo_empty,
    input  logic [CHAR_W-1:0] fifo_data,
    output logic              pop,
    output logic              line,
    output logic              idle,
    output logic              drained
);
    localparam int NARROW = CHAR_W - 1;
    localparam int SH_W   = CHAR_W + 2;
    localparam int REM_W  = $clog2(SH_W + 1);

    tx_st_e           st;
    logic [SH_W-1:0]  sh, ld_bits;
    logic [REM_W-1:0] rem, ld_rem, nbits;
    logic             line_q, end_tick;

    // Build the post-start bit image of the head character; unused slots stay 1 (stop level).
    always_comb begin
        ld_bits = '1;
        nbits   = REM_W'(NARROW);
        unique case (fmt)
            FMT_8N: begin
                ld_bits[NARROW-1:0] = fifo_data[NARROW-1:0];
                nbits               = REM_W'(NARROW);
            end
            FMT_8E: begin
                ld_bits[NARROW-1:0] = fifo_data[NARROW-1:0];
                ld_bits[NARROW]     = ^fifo_data[NARROW-1:0];
                nbits               = REM_W'(NARROW + 1);
            end
            FMT_8O: begin
                ld_bits[NARROW-1:0] = fifo_data[NARROW-1:0];
                ld_bits[NARROW]     = ~^fifo_data[NARROW-1:0];
                nbits               = REM_W'(NARROW + 1);
            end
            FMT_9N: begin
                ld_bits[CHAR_W-1:0] = fifo_data;
                nbits               = REM_W'(CHAR_W);
            end
        endcase
        ld_rem = nbits + REM_W'(1) + REM_W'(two_stop);
    end

    assign end_tick = (st == ST_SEND) && tick && (rem == '0);
    assign pop      = !abort && arm && !fifo_empty && ((st == ST_IDLE) || end_tick);
    assign drained  = !abort && end_tick && !pop && fifo_empty;
    assign idle     = (st == ST_IDLE);
    assign line     = line_q;

    // Sequence the frame: load, wait for tick, then shift one bit per tick.
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            st     <= ST_IDLE;
            sh     <= '1;
            rem    <= '0;
            line_q <= 1'b1;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (pop) begin
                        sh  <= ld_bits;
                        rem <= ld_rem;
                        if (tick) begin
                            line_q <= 1'b0;
                            st     <= ST_SEND;
                        end else begin
                            st <= ST_WAIT;
                        end
                    end
                end
                ST_WAIT: begin
                    if (tick) begin
                        line_q <= 1'b0;
                        st     <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (tick) begin
                        if (rem != '0) begin
                            line_q <= sh[0];
                            sh     <= {1'b1, sh[SH_W-1:1]};
                            rem    <= rem - REM_W'(1);
                        end else if (pop) begin
                            sh     <= ld_bits;
                            rem    <= ld_rem;
                            line_q <= 1'b0;
                        end else begin
                            line_q <= 1'b1;
                            st     <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/sertx_top.sv
// Buffered serial transmitter top: holding store, baud divider and shifter,
// plus the arm latch and interrupt pulse logic.
// Assumes: wr_data bits above the character width are don't-care; arming
// requires a rising change of tx_en observed while mod_en is high.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int CHAR_W = 9,
    parameter int DEPTH  = 4,
    parameter int DIV_W  = 16,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mod_en,
    input  logic              tx_en,
    input  logic [1:0]        fmt_sel,
    input  logic              two_stop,
    input  logic [DIV_W-1:0]  divisor,
    input  logic              irq_mode,
    input  logic              wr_valid,
    input  logic [WORD_W-1:0] wr_data,
    output logic              tx_line,
    output logic              buf_full,
    output logic              shift_empty,
    output logic              tx_irq
);
    logic              tx_en_q, arm_q, irq_q;
    logic              fifo_empty, fifo_full, fifo_pop, fifo_wr;
    logic [CHAR_W-1:0] fifo_head;
    logic              baud_tick, baud_run;
    logic              shift_idle, frame_drained;
    logic              unused_hi;

    assign unused_hi   = ^wr_data[WORD_W-1:CHAR_W];
    assign fifo_wr     = wr_valid && mod_en && !fifo_full;
    assign baud_run    = mod_en && (arm_q || !shift_idle);
    assign buf_full    = fifo_full;
    assign shift_empty = shift_idle;
    assign tx_irq      = irq_q;

    // Arm on a rising change of tx_en while enabled; disable or tx_en low disarms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q <= 1'b0;
            arm_q   <= 1'b0;
        end else begin
            tx_en_q <= tx_en;
            arm_q   <= mod_en && tx_en && (arm_q || !tx_en_q);
        end
    end

    // Register a one-cycle interrupt on hand-over or on full drain per irq_mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= mod_en && (irq_mode ? frame_drained : fifo_pop);
        end
    end

    sertx_fifo #(
        .WIDTH (CHAR_W),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!mod_en),
        .wr_en   (fifo_wr),
        .wr_data (wr_data[CHAR_W-1:0]),
        .rd_en   (fifo_pop),
        .rd_data (fifo_head),
        .empty   (fifo_empty),
        .full    (fifo_full)
    );

    sertx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (baud_run),
        .divisor (divisor),
        .tick    (baud_tick)
    );

    sertx_shifter #(
        .CHAR_W (CHAR_W)
    ) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .abort      (!mod_en),
        .arm        (arm_q),
        .tick       (baud_tick),
        .fmt        (fmt_e'(fmt_sel)),
        .two_stop   (two_stop),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_head),
        .pop        (fifo_pop),
        .line       (tx_line),
        .idle       (shift_idle),
        .drained    (frame_drained)
    );

endmodule

// File: rtl/sertx_chk.sv
// Property checker for sertx_top, attached by the bind below.
// Assumes: tick and pop are the internal baud tick and store hand-over strobes.
module sertx_chk (
    input logic clk,
    input logic rst_n,
    input logic mod_en,
    input logic irq_mode,
    input logic tx_line,
    input logic buf_full,
    input logic shift_empty,
    input logic tx_irq,
    input logic tick,
    input logic pop
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        shift_empty |-> tx_line); // R1

    AST_LINE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mod_en) && !$past(tick)) |-> $stable(tx_line)); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && mod_en && !pop) |=> buf_full); // R5

    AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (shift_empty && tx_line && !buf_full && !tx_irq)); // R10

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq |=> !tx_irq); // R11

    AST_IRQ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && !$past(irq_mode)) |-> !shift_empty); // R11

    AST_IRQ_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_irq && $past(irq_mode)) |-> (shift_empty && !$past(shift_empty))); // R12

endmodule

bind sertx_top sertx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mod_en      (mod_en),
    .irq_mode    (irq_mode),
    .tx_line     (tx_line),
    .buf_full    (buf_full),
    .shift_empty (shift_empty),
    .tx_irq      (tx_irq),
    .tick        (baud_tick),
    .pop         (fifo_pop)
);

// File: tb/test_sertx_top.sv
// Directed bench for sertx_top: one task per scenario, serial line decoded
// by sampling mid-bit on falling clock edges.
module test_sertx_top;
    localparam int DIV = 3;
    localparam int BP  = DIV + 1;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        mod_en = 1'b0, tx_en = 1'b0, two_stop = 1'b0, irq_mode = 1'b0;
    logic        wr_valid = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic [15:0] divisor = 16'(DIV);
    logic [15:0] wr_data = '0;
    logic        tx_line, buf_full, shift_empty, tx_irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    sertx_top i_sertx_top (
        .clk(clk), .rst_n(rst_n), .mod_en(mod_en), .tx_en(tx_en),
        .fmt_sel(fmt_sel), .two_stop(two_stop), .divisor(divisor),
        .irq_mode(irq_mode), .wr_valid(wr_valid), .wr_data(wr_data),
        .tx_line(tx_line), .buf_full(buf_full), .shift_empty(shift_empty),
        .tx_irq(tx_irq)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] v);
        wr_valid = 1'b1;
        wr_data  = v;
        step();
        wr_valid = 1'b0;
        wr_data  = '0;
    endtask

    task automatic quiesce();
        tx_en  = 1'b0;
        mod_en = 1'b0;
        step();
        step();
        mod_en = 1'b1;
        step();
    endtask

    task automatic arm();
        tx_en = 1'b1;
        step();
    endtask

    // Find the start bit, then sample each bit in its middle.
    task automatic rx_frame(input int nd, input bit hp, input int ns,
                            output logic [8:0] d, output logic p, output logic ok);
        int guard = 0;
        d  = '0;
        p  = 1'b0;
        ok = 1'b1;
        while (tx_line !== 1'b0 && guard < 3000) begin
            step();
            guard++;
        end
        if (guard >= 3000) begin
            ok = 1'b0;
            return;
        end
        repeat ((BP - 1) / 2) step();
        if (tx_line !== 1'b0) ok = 1'b0;
        for (int i = 0; i < nd; i++) begin
            repeat (BP) step();
            d[i] = tx_line;
        end
        if (hp) begin
            repeat (BP) step();
            p = tx_line;
        end
        for (int i = 0; i < ns; i++) begin
            repeat (BP) step();
            if (tx_line !== 1'b1) ok = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1", "tx_line after reset", 32'(tx_line), 32'd1);
        chk("R1", "shift_empty after reset", 32'(shift_empty), 32'd1);
        chk("R1", "buf_full after reset", 32'(buf_full), 32'd0);
        chk("R1", "tx_irq after reset", 32'(tx_irq), 32'd0);
    endtask

    task automatic t_formats();
        logic [8:0]  d;
        logic        p, ok;
        logic [15:0] v;
        for (int f = 0; f < 4; f++) begin
            for (int s = 0; s < 2; s++) begin
                quiesce();
                fmt_sel  = 2'(f);
                two_stop = 1'(s);
                v = 16'hFE00 | 16'((9'h1A5 ^ 9'(f * 37 + s * 90)));
                wr(v);
                arm();
                rx_frame((f == 3) ? 9 : 8, (f == 1 || f == 2), s + 1, d, p, ok);
                chk("R2", "start and stop levels", 32'(ok), 32'd1);
                chk("R3", "decoded data",
                    32'(d), (f == 3) ? 32'(v[8:0]) : 32'(v[7:0]));
                if (f == 1) chk("R3", "even parity bit", 32'(p), 32'(^v[7:0]));
                if (f == 2) chk("R3", "odd parity bit", 32'(p), 32'(~^v[7:0]));
                chk("R4", "busy during last stop", 32'(shift_empty), 32'd0);
                repeat (BP - 1) step();
                chk("R4", "empty right after last stop", 32'(shift_empty), 32'd1);
            end
        end
        fmt_sel  = 2'b00;
        two_stop = 1'b0;
    endtask

    task automatic t_bit_time();
        int low = 0;
        int guard = 0;
        quiesce();
        divisor = 16'd6;
        wr(16'h0001);
        arm();
        while (tx_line !== 1'b0 && guard < 100) begin
            step();
            guard++;
        end
        while (tx_line === 1'b0 && low < 100) begin
            step();
            low++;
        end
        chk("R2", "start bit length at divisor 6", 32'(low), 32'd7);
        quiesce();
        divisor = 16'(DIV);
    endtask

    task automatic t_full();
        logic [8:0] d;
        logic       p, ok;
        quiesce();
        for (int i = 0; i < 4; i++) begin
            wr(16'h00A1 + 16'(i));
            if (i == 2) chk("R5", "not full at 3", 32'(buf_full), 32'd0);
        end
        chk("R5", "full at 4", 32'(buf_full), 32'd1);
        wr(16'h00A5);
        chk("R5", "still full after rejected write", 32'(buf_full), 32'd1);
        arm();
        for (int i = 0; i < 4; i++) begin
            rx_frame(8, 1'b0, 1, d, p, ok);
            chk("R5", "order after overflow", 32'(d), 32'h0A1 + 32'(i));
        end
        repeat (40) step();
        chk("R5", "no fifth character", 32'(shift_empty), 32'd1);
        chk("R5", "line idle afterwards", 32'(tx_line), 32'd1);
    endtask

    task automatic t_capacity();
        logic [8:0] d;
        logic       p, ok;
        quiesce();
        arm();
        wr(16'h00B0);
        step();
        chk("R6", "shifter loaded", 32'(shift_empty), 32'd0);
        chk("R6", "store empty after hand-over", 32'(buf_full), 32'd0);
        for (int i = 1; i < 5; i++) wr(16'h00B0 + 16'(i));
        chk("R6", "full with five pending", 32'(buf_full), 32'd1);
        wr(16'h00BF);
        for (int i = 0; i < 5; i++) begin
            rx_frame(8, 1'b0, 1, d, p, ok);
            chk("R6", "five in order", 32'(d), 32'h0B0 + 32'(i));
        end
        repeat (40) step();
        chk("R6", "sixth write discarded", 32'(shift_empty), 32'd1);
    endtask

    task automatic t_en_after_wr();
        logic [8:0] d;
        logic       p, ok;
        quiesce();
        wr(16'h00C3);
        step();
        chk("R9", "disarmed keeps character queued", 32'(shift_empty), 32'd1);
        tx_en = 1'b1;
        step();
        chk("R7", "line high after arming edge", 32'(tx_line), 32'd1);
        step();
        chk("R7", "start bit on next edge", 32'(tx_line), 32'd0);
        chk("R11", "irq on hand-over", 32'(tx_irq), 32'd1);
        rx_frame(8, 1'b0, 1, d, p, ok);
        chk("R7", "data after early write", 32'(d), 32'h0C3);
    endtask

    task automatic t_wr_after_en();
        logic [8:0] d;
        logic       p, ok;
        quiesce();
        arm();
        repeat (4) step();
        wr(16'h005A);
        chk("R8", "not yet handed over", 32'(shift_empty), 32'd1);
        chk("R11", "no irq before hand-over", 32'(tx_irq), 32'd0);
        step();
        chk("R8", "handed over one edge after write", 32'(shift_empty), 32'd0);
        chk("R11", "irq with hand-over", 32'(tx_irq), 32'd1);
        chk("R8", "line still idle", 32'(tx_line), 32'd1);
        step();
        chk("R11", "irq lasts one cycle", 32'(tx_irq), 32'd0);
        step();
        chk("R8", "waiting for baud tick", 32'(tx_line), 32'd1);
        step();
        chk("R8", "start on baud tick", 32'(tx_line), 32'd0);
        rx_frame(8, 1'b0, 1, d, p, ok);
        chk("R8", "data after late write", 32'(d), 32'h05A);
    endtask

    task automatic t_irq_drain();
        int pulses = 0;
        logic prev_empty;
        quiesce();
        irq_mode = 1'b1;
        wr(16'h00D0);
        wr(16'h00D1);
        arm();
        prev_empty = shift_empty;
        for (int i = 0; i < 120; i++) begin
            if (tx_irq === 1'b1) begin
                pulses++;
                chk("R12", "pulse when drained", 32'(shift_empty && !prev_empty), 32'd1);
            end
            prev_empty = shift_empty;
            step();
        end
        chk("R12", "single drain pulse", 32'(pulses), 32'd1);
        irq_mode = 1'b0;
    endtask

    task automatic t_txen_off();
        logic [8:0] d;
        logic       p, ok;
        quiesce();
        wr(16'h00E0);
        wr(16'h00E1);
        arm();
        tx_en = 1'b0;
        rx_frame(8, 1'b0, 1, d, p, ok);
        chk("R9", "current frame completes", 32'(d), 32'h0E0);
        repeat (60) step();
        chk("R9", "next character held", 32'(shift_empty), 32'd1);
        tx_en = 1'b1;
        step();
        rx_frame(8, 1'b0, 1, d, p, ok);
        chk("R9", "held character sent after re-arm", 32'(d), 32'h0E1);
    endtask

    task automatic t_disable();
        logic [8:0] d;
        logic       p, ok;
        int guard = 0;
        quiesce();
        arm();
        for (int i = 0; i < 5; i++) wr(16'h0070 + 16'(i));
        chk("R10", "full before disable", 32'(buf_full), 32'd1);
        while (tx_line !== 1'b0 && guard < 100) begin
            step();
            guard++;
        end
        repeat (6) step();
        mod_en = 1'b0;
        step();
        chk("R10", "line forced high", 32'(tx_line), 32'd1);
        chk("R10", "shifter emptied", 32'(shift_empty), 32'd1);
        chk("R10", "full cleared", 32'(buf_full), 32'd0);
        wr(16'h0099);
        mod_en = 1'b1;
        repeat (20) step();
        chk("R9", "held tx_en does not re-arm", 32'(shift_empty), 32'd1);
        tx_en = 1'b0;
        step();
        tx_en = 1'b1;
        step();
        repeat (40) step();
        chk("R10", "flushed and disabled write ignored", 32'(shift_empty), 32'd1);
        chk("R10", "line idle", 32'(tx_line), 32'd1);
        wr(16'h00F5);
        rx_frame(8, 1'b0, 1, d, p, ok);
        chk("R10", "works after re-enable", 32'(d), 32'h0F5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_formats();
        t_bit_time();
        t_full();
        t_capacity();
        t_en_after_wr();
        t_wr_after_en();
        t_irq_drain();
        t_txen_off();
        t_disable();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule